// File: doc/BRIEF.md
# Single-Bank Packet DRAM Transaction Sequencer

This block sits on the controller side of a packet-based DRAM and runs one memory transaction at a time against a single bank. The host hands over a read or a write together with a bank, a row and one or two column addresses. The sequencer then sends request packets on a narrow request bus in a fixed order: an activate carrying bank and row, one or two column commands carrying bank and column, and a closing precharge carrying only the bank. It drives write data packets, or captures returning read data packets, on the data bus at fixed cycle offsets from each column command.

Every spacing is a synthesis-time parameter. These are the activate-to-column delays for each direction, the column-to-column gap, the column-to-precharge delays for each direction, and the command-to-data latencies for each direction. Each packet is modelled as one per-cycle slot. A request slot is 12 lines by 2 bit windows (24 bits), and a data slot is 16 lines by 16 bit windows (256 bits). For reads, precharge may go out before the last read data returns. The sequencer keeps capturing that data at its scheduled cycle, hands it to the host with a valid strobe in column order, and pulses done when the transaction is complete.

Top module: `pkt_dram_seq`

## Requirements
- R1: After reset, req_ready is 1 and rq_valid, dq_oe, rd_valid and done are all 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle up to and including the cycle where done is 1, and is 1 again in the cycle after that.
- R3: The request packet layout is op in bits [23:22], bank in bits [21:19], and address zero-extended in bits [11:0]. The op codes are 01 activate, 10 read, 11 write and 00 precharge. The activate carries the row and is issued (rq_valid=1) in the first cycle after acceptance, called cycle 0.
- R4: The first column command is issued in cycle 1 for a write and in cycle 5 for a read.
- R5: When two columns are requested (req_two=1), the second column command follows the first by 2 cycles and carries req_col1. With req_two=0 only one column command is issued.
- R6: Precharge is issued 11 cycles after the last write command, or 3 cycles after the last read command. It carries the bank, with the address field zero.
- R7: For each write command, dq_oe is 1 exactly 3 cycles later, and dq_out carries req_wdata0 for the first column and req_wdata1 for the second. At all other cycles dq_oe is 0.
- R8: For each read command, dq_in is captured exactly 6 cycles later, even when precharge has already been issued. In that cycle rd_valid is 1, rd_data equals dq_in and rd_index gives the column (0 first, 1 second). rd_valid is 0 at all other cycles.
- R9: done is a one-cycle pulse in the later of the precharge cycle and the last data cycle. At most one request packet is issued per cycle, and rq_valid is 0 in every cycle without a packet.
- R10: Request inputs presented while req_ready is 0 are ignored and do not change the packets or data of the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_two | input | 1 | 1 for two column accesses, 0 for one |
| req_bank | input | 3 | Bank address |
| req_row | input | 12 | Row address |
| req_col0 | input | 6 | First column address |
| req_col1 | input | 6 | Second column address |
| req_wdata0 | input | 256 | Write data packet for first column |
| req_wdata1 | input | 256 | Write data packet for second column |
| rq_valid | output | 1 | Request packet slot occupied |
| rq_pkt | output | 24 | Request packet |
| dq_oe | output | 1 | Controller drives the data slot |
| dq_out | output | 256 | Write data packet |
| dq_in | input | 256 | Read data packet from the device |
| rd_valid | output | 1 | Read data returned to host |
| rd_data | output | 256 | Returned read data |
| rd_index | output | 1 | Column index of returned data |
| done | output | 1 | Transaction complete pulse |

## Verification
The bench goes after the asymmetric timeline. A design that shared one activate-to-column delay or one precharge delay between directions would put the read column or the precharge in the wrong slot. A design that ended a read transaction at precharge would drop the last read packet and raise ready too early. Single-column requests check that no phantom second command or data slot appears. Requests held on the inputs during a busy transaction, and requests presented the cycle ready returns, show whether the latched request is overwritten or a back-to-back request is lost.

// File: rtl/pkt_dram_seq.sv
module pkt_dram_seq #(
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 6,
  parameter int RQ_LINES = 12,
  parameter int RQ_WIN   = 2,
  parameter int DQ_LINES = 16,
  parameter int DQ_WIN   = 16,
  parameter int T_ACT_WR = 1,
  parameter int T_ACT_RD = 5,
  parameter int T_CC     = 2,
  parameter int T_WR_PRE = 11,
  parameter int T_RD_PRE = 3,
  parameter int T_WLAT   = 3,
  parameter int T_RLAT   = 6,
  localparam int RQ_W    = RQ_LINES * RQ_WIN,
  localparam int PKT_W   = DQ_LINES * DQ_WIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_two,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col0,
  input  logic [COL_W-1:0]  req_col1,
  input  logic [PKT_W-1:0]  req_wdata0,
  input  logic [PKT_W-1:0]  req_wdata1,
  output logic              rq_valid,
  output logic [RQ_W-1:0]   rq_pkt,
  output logic              dq_oe,
  output logic [PKT_W-1:0]  dq_out,
  input  logic [PKT_W-1:0]  dq_in,
  output logic              rd_valid,
  output logic [PKT_W-1:0]  rd_data,
  output logic              rd_index,
  output logic              done
);

  localparam int T_ACT_MAX = (T_ACT_RD > T_ACT_WR) ? T_ACT_RD : T_ACT_WR;
  localparam int T_TAIL_W  = (T_WR_PRE > T_WLAT) ? T_WR_PRE : T_WLAT;
  localparam int T_TAIL_R  = (T_RD_PRE > T_RLAT) ? T_RD_PRE : T_RLAT;
  localparam int T_TAIL    = (T_TAIL_W > T_TAIL_R) ? T_TAIL_W : T_TAIL_R;
  localparam int T_MAX     = T_ACT_MAX + T_CC + T_TAIL + 2;
  localparam int CNT_W     = $clog2(T_MAX + 1);
  localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int OP_LO     = RQ_W - 2;
  localparam int BANK_LO   = OP_LO - BANK_W;

  localparam logic [1:0] OP_PRE = 2'b00;
  localparam logic [1:0] OP_ACT = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_WR  = 2'b11;

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic              l_wr, l_two;
  logic [BANK_W-1:0] l_bank;
  logic [ROW_W-1:0]  l_row;
  logic [COL_W-1:0]  l_col0, l_col1;
  logic [PKT_W-1:0]  l_wd0, l_wd1;

  logic [CNT_W-1:0]  t_c0, t_c1, t_last, t_pre, t_d0, t_d1, t_dlast, t_end;

  assign t_c0    = CNT_W'(l_wr ? T_ACT_WR : T_ACT_RD);
  assign t_c1    = t_c0 + CNT_W'(T_CC);
  assign t_last  = l_two ? t_c1 : t_c0;
  assign t_pre   = t_last + CNT_W'(l_wr ? T_WR_PRE : T_RD_PRE);
  assign t_d0    = t_c0 + CNT_W'(l_wr ? T_WLAT : T_RLAT);
  assign t_d1    = t_c1 + CNT_W'(l_wr ? T_WLAT : T_RLAT);
  assign t_dlast = l_two ? t_d1 : t_d0;
  assign t_end   = (t_pre > t_dlast) ? t_pre : t_dlast;

  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      l_wr   <= 1'b0;
      l_two  <= 1'b0;
      l_bank <= '0;
      l_row  <= '0;
      l_col0 <= '0;
      l_col1 <= '0;
      l_wd0  <= '0;
      l_wd1  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      l_wr   <= req_write;
      l_two  <= req_two;
      l_bank <= req_bank;
      l_row  <= req_row;
      l_col0 <= req_col0;
      l_col1 <= req_col1;
      l_wd0  <= req_wdata0;
      l_wd1  <= req_wdata1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == t_end) busy <= 1'b0;
    end
  end

  wire is_act = busy && cnt == '0;
  wire is_c0  = busy && cnt == t_c0;
  wire is_c1  = busy && l_two && cnt == t_c1;
  wire is_pre = busy && cnt == t_pre;
  wire is_d0  = busy && cnt == t_d0;
  wire is_d1  = busy && l_two && cnt == t_d1;

  logic [1:0]        op;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    op   = OP_PRE;
    addr = '0;
    if (is_act) begin
      op   = OP_ACT;
      addr = ADDR_W'(l_row);
    end else if (is_c0 || is_c1) begin
      op   = l_wr ? OP_WR : OP_RD;
      addr = ADDR_W'(is_c1 ? l_col1 : l_col0);
    end
  end

  assign req_ready = !busy;
  assign rq_valid  = is_act || is_c0 || is_c1 || is_pre;

  always_comb begin
    rq_pkt = '0;
    if (rq_valid) begin
      rq_pkt[RQ_W-1:OP_LO]       = op;
      rq_pkt[OP_LO-1:BANK_LO]    = l_bank;
      rq_pkt[ADDR_W-1:0]         = addr;
    end
  end

  assign dq_oe    = l_wr && (is_d0 || is_d1);
  assign dq_out   = !dq_oe ? '0 : (is_d1 ? l_wd1 : l_wd0);
  assign rd_valid = !l_wr && (is_d0 || is_d1);
  assign rd_data  = rd_valid ? dq_in : '0;
  assign rd_index = rd_valid && is_d1;
  assign done     = busy && cnt == t_end;

  // R9
  one_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_act, is_c0, is_c1, is_pre}));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && !done);

  // R7
  dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && rd_valid));

  // R3
  act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_pkt[RQ_W-1:OP_LO] == OP_ACT) |-> !req_ready);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(l_bank) && $stable(l_wr));

endmodule

// File: tb/tb_pkt_dram_seq.sv
module tb_pkt_dram_seq;
  localparam int PKT_W = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_two = 1'b0;
  logic [2:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [5:0]  req_col0 = '0, req_col1 = '0;
  logic [PKT_W-1:0] req_wdata0 = '0, req_wdata1 = '0, dq_in = '0;
  logic req_ready, rq_valid, dq_oe, rd_valid, rd_index, done;
  logic [23:0] rq_pkt;
  logic [PKT_W-1:0] dq_out, rd_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pkt_dram_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_two(req_two), .req_bank(req_bank),
    .req_row(req_row), .req_col0(req_col0), .req_col1(req_col1),
    .req_wdata0(req_wdata0), .req_wdata1(req_wdata1), .rq_valid(rq_valid),
    .rq_pkt(rq_pkt), .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index), .done(done)
  );

  function automatic logic [PKT_W-1:0] rnd_pkt();
    logic [PKT_W-1:0] v;
    for (int i = 0; i < PKT_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [23:0] mk_pkt(logic [1:0] op, logic [2:0] b, logic [11:0] a);
    return {op, b, 7'd0, a};
  endfunction

  task automatic chk(string tag, logic [PKT_W-1:0] act, logic [PKT_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic run_txn(bit wr, bit two, bit noisy);
    logic [2:0] b = 3'($urandom);
    logic [11:0] row = 12'($urandom);
    logic [5:0] c0 = 6'($urandom), c1 = 6'($urandom);
    logic [PKT_W-1:0] w0 = rnd_pkt(), w1 = rnd_pkt();
    int tc0 = wr ? 1 : 5;
    int tc1 = tc0 + 2;
    int tl = two ? tc1 : tc0;
    int tpre = tl + (wr ? 11 : 3);
    int lat = wr ? 3 : 6;
    int tdl = tl + lat;
    int tend = (tpre > tdl) ? tpre : tdl;
    req_valid = 1'b1; req_write = wr; req_two = two; req_bank = b;
    req_row = row; req_col0 = c0; req_col1 = c1; req_wdata0 = w0; req_wdata1 = w1;
    @(posedge clk);
    for (int k = 0; k <= tend + 1; k++) begin
      logic e_rv, e_oe, e_rd, e_idx;
      logic [23:0] e_pkt;
      logic [PKT_W-1:0] e_dq;
      @(negedge clk);
      dq_in = rnd_pkt();
      // R10: hold garbage on inputs while busy
      req_valid = noisy && k < tend;
      req_write = 1'($urandom); req_two = 1'($urandom); req_bank = 3'($urandom);
      req_row = 12'($urandom); req_col0 = 6'($urandom); req_col1 = 6'($urandom);
      req_wdata0 = rnd_pkt(); req_wdata1 = rnd_pkt();
      #1;
      e_rv = 1'b1; e_pkt = '0;
      if (k == 0) e_pkt = mk_pkt(2'b01, b, row);
      else if (k == tc0) e_pkt = mk_pkt(wr ? 2'b11 : 2'b10, b, {6'd0, c0});
      else if (two && k == tc1) e_pkt = mk_pkt(wr ? 2'b11 : 2'b10, b, {6'd0, c1});
      else if (k == tpre) e_pkt = mk_pkt(2'b00, b, 12'd0);
      else e_rv = 1'b0;
      e_oe = wr && (k == tc0 + lat || (two && k == tc1 + lat));
      e_rd = !wr && (k == tc0 + lat || (two && k == tc1 + lat));
      e_idx = e_rd && two && k == tc1 + lat;
      e_dq = e_oe ? ((two && k == tc1 + lat) ? w1 : w0) : '0;
      if (k <= tend) begin
        chk("R3/R4/R5/R6/R9 rq_valid", PKT_W'(rq_valid), PKT_W'(e_rv));
        chk("R3/R4/R5/R6 rq_pkt", PKT_W'(rq_pkt), PKT_W'(e_pkt));
        chk("R7 dq_oe", PKT_W'(dq_oe), PKT_W'(e_oe));
        chk("R7 dq_out", dq_out, e_dq);
        chk("R8 rd_valid", PKT_W'(rd_valid), PKT_W'(e_rd));
        if (e_rd) begin
          chk("R8 rd_data", rd_data, dq_in);
          chk("R8 rd_index", PKT_W'(rd_index), PKT_W'(e_idx));
        end
        chk("R9 done", PKT_W'(done), PKT_W'(k == tend));
        chk("R2 ready busy", PKT_W'(req_ready), '0);
      end else begin
        chk("R2 ready back", PKT_W'(req_ready), PKT_W'(1));
        chk("R9 done end", PKT_W'(done), '0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready", PKT_W'(req_ready), PKT_W'(1));
    chk("R1 rq_valid", PKT_W'(rq_valid), '0);
    chk("R1 dq_oe", PKT_W'(dq_oe), '0);
    chk("R1 rd_valid", PKT_W'(rd_valid), '0);
    chk("R1 done", PKT_W'(done), '0);
    run_txn(1, 1, 0);
    run_txn(1, 0, 0);
    run_txn(0, 1, 0);
    run_txn(0, 0, 0);
    run_txn(0, 1, 1);
    run_txn(1, 1, 1);
    for (int n = 0; n < 60; n++) run_txn(1'($urandom), 1'($urandom), 1'($urandom));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule